// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block records which reset source brought the device down and keeps that record until software clears it. Three single-cycle reset pulses are sampled on the system clock: a supply-undervoltage reset, an early-fault watchdog reset and a late-fault watchdog reset. Each pulse sets its own flag. A manual pushbutton reset also arrives as an input, but it sets nothing. After any reset, a read that shows all three flags clear therefore identifies a manual reset.

The flags are held in flops whose only reset is a dedicated storage-initialise input. The system resets they record do not clear them, so the information survives the reset it describes. Flags build up across several resets. Software reads one 8-bit status register through a plain address / write-enable / write-data / read-data port. It clears flags by writing ones to them.

Top module: `rcause_top`

## Requirements
- R1: While `storeInitN` is low, all flags are cleared, and a read of the status register (address 0x09) returns 0x00.
- R2: A high `uvRstPulse` at a rising clock edge sets bit 5 of the status register, and the bit is visible after that edge.
- R3: A high `wdEarlyPulse` at a clock edge sets bit 7, and a high `wdLatePulse` at a clock edge sets bit 6.
- R4: `manualRst` has no effect on any flag.
- R5: Hardware never clears a flag. A flag keeps its value until software clears it or `storeInitN` goes low.
- R6: A write to address 0x09 clears each flag bit (7, 6, 5) whose write-data bit is 1. Bits written as 0 keep their value.
- R7: If a flag's reset pulse and a software clear of that same bit fall on the same clock edge, the flag ends up set.
- R8: Flags accumulate: several flags can read as set at the same time, and the register always reads back the exact set of sources that occurred since each flag was last cleared.
- R9: Bits 4 to 0 of the status register always read as 0, and writing to them changes nothing.
- R10: A read at any address other than 0x09 returns 0x00. A write to any other address leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| storeInitN | input | 1 | Asynchronous active-low initialise of the flag storage |
| uvRstPulse | input | 1 | Undervoltage reset event, sampled on clk |
| wdEarlyPulse | input | 1 | Early-fault watchdog reset event |
| wdLatePulse | input | 1 | Late-fault watchdog reset event |
| manualRst | input | 1 | Pushbutton reset indication (records nothing) |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe, taken at the clock edge |
| busWrData | input | 8 | Write data; a 1 in bits 7..5 clears that flag |
| busRdData | output | 8 | Read data for the register selected by busAddr |

## Verification
A hardware set and a software clear can land on the same edge, either on the same flag or on different flags. The bench provokes this in directed cases, with a clear aimed at each flag while its own pulse is high, and also through random stimulus in which pulses and clear writes are drawn independently on every cycle. A bench model applies "set, otherwise keep unless cleared" to each flag and judges the result. Every read-back is compared against that model, so a reversed priority shows up as a flag that is missing.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int unsigned FLAG_NUM = 3;
  // flag index order inside the flag vector; index + FLAG_LSB = register bit
  localparam int unsigned IDX_UV    = 0;
  localparam int unsigned IDX_LATE  = 1;
  localparam int unsigned IDX_EARLY = 2;

  typedef struct packed {
    logic                regHit;
    logic [FLAG_NUM-1:0] setMask;
    logic [FLAG_NUM-1:0] clrMask;
  } flagStrobe_t;
endpackage

// File: rtl/rcause_ctrl.sv
module rcause_ctrl
  import rcause_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h09,
  parameter int unsigned FLAG_LSB = 5
) (
  input  logic              uvRstPulse,
  input  logic              wdEarlyPulse,
  input  logic              wdLatePulse,
  input  logic              manualRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output flagStrobe_t       strobe
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + FLAG_NUM - 1;

  logic [FLAG_NUM-1:0] eventVec;
  logic                unusedInputs;

  // the pushbutton reset and the non-flag data bits carry no information here
  assign unusedInputs = manualRst ^ (^busWrData);

  always_comb begin
    eventVec            = '0;
    eventVec[IDX_UV]    = uvRstPulse;
    eventVec[IDX_LATE]  = wdLatePulse;
    eventVec[IDX_EARLY] = wdEarlyPulse;
  end

  always_comb begin
    strobe.regHit  = (busAddr == REG_ADDR);
    strobe.setMask = eventVec;
    strobe.clrMask = (busWrEn && strobe.regHit) ? busWrData[FLAG_MSB:FLAG_LSB] : '0;
  end
endmodule

// File: rtl/rcause_flags.sv
module rcause_flags
  import rcause_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FLAG_LSB = 5
) (
  input  logic                clk,
  input  logic                storeInitN,
  input  flagStrobe_t         strobe,
  output logic [FLAG_NUM-1:0] flagQ,
  output logic [DATA_W-1:0]   rdData
);
  localparam int unsigned FLAG_MSB = FLAG_LSB + FLAG_NUM - 1;

  for (genvar g = 0; g < FLAG_NUM; g++) begin : gFlag
    logic flagNext;
    // a set on the same edge overrides a software clear
    assign flagNext = strobe.setMask[g] | (flagQ[g] & ~strobe.clrMask[g]);

    always_ff @(posedge clk or negedge storeInitN) begin
      if (!storeInitN) flagQ[g] <= 1'b0;
      else             flagQ[g] <= flagNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.regHit) rdData[FLAG_MSB:FLAG_LSB] = flagQ;
  end
endmodule

// File: rtl/rcause_top.sv
module rcause_top
  import rcause_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h09,
  parameter int unsigned FLAG_LSB = 5
) (
  input  logic              clk,
  input  logic              storeInitN,
  input  logic              uvRstPulse,
  input  logic              wdEarlyPulse,
  input  logic              wdLatePulse,
  input  logic              manualRst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  flagStrobe_t         strobe;
  logic [FLAG_NUM-1:0] flagQ;

  rcause_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .FLAG_LSB(FLAG_LSB)
  ) u_ctrl (
    .uvRstPulse  (uvRstPulse),
    .wdEarlyPulse(wdEarlyPulse),
    .wdLatePulse (wdLatePulse),
    .manualRst   (manualRst),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busWrData   (busWrData),
    .strobe      (strobe)
  );

  rcause_flags #(
    .DATA_W(DATA_W), .FLAG_LSB(FLAG_LSB)
  ) u_flags (
    .clk       (clk),
    .storeInitN(storeInitN),
    .strobe    (strobe),
    .flagQ     (flagQ),
    .rdData    (busRdData)
  );
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk
  import rcause_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h09,
  parameter int unsigned FLAG_LSB = 5
) (
  input logic                clk,
  input logic                storeInitN,
  input logic                uvRstPulse,
  input logic                wdEarlyPulse,
  input logic                wdLatePulse,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [DATA_W-1:0]   busWrData,
  input logic [DATA_W-1:0]   busRdData,
  input logic [FLAG_NUM-1:0] flagQ
);
  logic clrUv;
  assign clrUv = busWrEn && (busAddr == REG_ADDR) && busWrData[FLAG_LSB + IDX_UV];

  // R2
  uv_sets_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    uvRstPulse |=> flagQ[IDX_UV]);

  // R3
  early_sets_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    wdEarlyPulse |=> flagQ[IDX_EARLY]);

  // R3
  late_sets_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    wdLatePulse |=> flagQ[IDX_LATE]);

  // R5
  uv_holds_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    (!uvRstPulse && !clrUv) |=> $stable(flagQ[IDX_UV]));

  // R6
  uv_clears_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    (clrUv && !uvRstPulse) |=> !flagQ[IDX_UV]);

  // R9
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    busRdData[FLAG_LSB-1:0] == '0);

  // R10
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!storeInitN)
    (busAddr != REG_ADDR) |-> (busRdData == '0));
endmodule

bind rcause_top rcause_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .FLAG_LSB(FLAG_LSB)
) u_chk (
  .clk         (clk),
  .storeInitN  (storeInitN),
  .uvRstPulse  (uvRstPulse),
  .wdEarlyPulse(wdEarlyPulse),
  .wdLatePulse (wdLatePulse),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .flagQ       (flagQ)
);

// File: tb/test_rcause_top.sv
module test_rcause_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG = 8'h09;

  logic clk = 1'b0;
  logic storeInitN = 1'b0;
  logic uvRstPulse = 1'b0, wdEarlyPulse = 1'b0, wdLatePulse = 1'b0, manualRst = 1'b0;
  logic [7:0] busAddr = REG;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [2:0] expFlags = '0;  // {early, late, uv}

  always #(CLK_PERIOD/2) clk = ~clk;

  rcause_top i_rcause_top (
    .clk(clk), .storeInitN(storeInitN), .uvRstPulse(uvRstPulse),
    .wdEarlyPulse(wdEarlyPulse), .wdLatePulse(wdLatePulse), .manualRst(manualRst),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  function automatic logic [2:0] nextFlags(logic [2:0] cur, logic [2:0] setV,
                                           logic we, logic [7:0] addr, logic [7:0] data);
    logic [2:0] clrV;
    clrV = (we && addr == REG) ? data[7:5] : 3'b000;
    return setV | (cur & ~clrV);
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] f, logic [7:0] addr);
    return (addr == REG) ? {f, 5'b00000} : 8'h00;
  endfunction

  task automatic check(string tag, logic [7:0] expV);
    testsRun++;
    if (busRdData !== expV) begin
      testsFailed++;
      $display("FAIL %s: read %02h expected %02h", tag, busRdData, expV);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check shortly after
  task automatic step(string tag, logic uv, logic late, logic early, logic man,
                      logic [7:0] addr, logic we, logic [7:0] data);
    @(negedge clk);
    uvRstPulse = uv; wdLatePulse = late; wdEarlyPulse = early; manualRst = man;
    busAddr = addr; busWrEn = we; busWrData = data;
    @(posedge clk);
    expFlags = nextFlags(expFlags, {early, late, uv}, we, addr, data);
    #1;
    check(tag, expRead(expFlags, addr));
  endtask

  task automatic idleRead(string tag, logic [7:0] addr);
    step(tag, 1'b0, 1'b0, 1'b0, 1'b0, addr, 1'b0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));

    // R1: reset state
    #(CLK_PERIOD * 2 + 1);
    check("R1", 8'h00);
    @(negedge clk); storeInitN = 1'b1;
    idleRead("R1", REG);

    // R2, R3 individual sets
    step("R2", 1, 0, 0, 0, REG, 0, 8'h00);
    step("R2", 0, 0, 0, 0, REG, 1, 8'h20);
    step("R3", 0, 0, 1, 0, REG, 0, 8'h00);
    step("R3", 0, 1, 0, 0, REG, 0, 8'h00);
    // R8 accumulate
    step("R8", 1, 0, 0, 0, REG, 0, 8'h00);
    if (expFlags != 3'b111) begin testsFailed++; $display("FAIL R8: model %b expected 111", expFlags); end
    // R5 holds across idle cycles
    for (int i = 0; i < 5; i++) idleRead("R5", REG);
    // R4 manual reset does nothing
    step("R4", 0, 0, 0, 1, REG, 0, 8'h00);
    step("R4", 0, 0, 0, 1, REG, 0, 8'h00);
    // R10 other address reads zero, write there ignored
    step("R10", 0, 0, 0, 0, 8'h08, 1, 8'hFF);
    idleRead("R10", REG);
    step("R10", 0, 0, 0, 0, 8'h19, 1, 8'hE0);
    idleRead("R10", REG);
    // R9 low bits write no effect, read zero
    step("R9", 0, 0, 0, 0, REG, 1, 8'h1F);
    // R6 partial W1C
    step("R6", 0, 0, 0, 0, REG, 1, 8'h40);
    step("R6", 0, 0, 0, 0, REG, 1, 8'h00);
    // R7 set beats clear, per flag
    step("R7", 1, 0, 0, 0, REG, 1, 8'h20);
    step("R7", 0, 1, 0, 0, REG, 1, 8'h40);
    step("R7", 0, 0, 1, 0, REG, 1, 8'h80);
    step("R6", 0, 0, 0, 0, REG, 1, 8'hE0);
    // R4 manual reset after clear: reads zero
    step("R4", 0, 0, 0, 1, REG, 0, 8'h00);
    // R1 reset mid-run
    step("R1", 1, 1, 1, 0, REG, 0, 8'h00);
    @(negedge clk);
    uvRstPulse = 0; wdLatePulse = 0; wdEarlyPulse = 0;
    storeInitN = 1'b0; expFlags = '0;
    #1; check("R1", 8'h00);
    @(negedge clk); storeInitN = 1'b1;
    idleRead("R1", REG);

    // R8 random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : REG;
      step("R8", ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, a, ($urandom % 3) == 0, 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule